// File: doc/BRIEF.md
# Dual Edge Pulse Capture Unit

This block timestamps two selected edges of one asynchronous input against an external free-running counter. Two linked capture registers work as a pair. The first register holds the counter value at the initial edge, and the second holds the value at the final edge. Choosing opposite edges measures a high or a low pulse. Choosing the same edge type, or either edge, measures a period or an interval. The width between the two stamps is presented directly on an output and is correct across one counter wrap.

Software configures the unit through a small register port. It picks the edges, enables the paired-capture function and sets an arm bit. Two status flags report progress. In one-shot operation the unit clears its own arm bit after the final edge and holds both values until software re-arms it. In continuous operation it keeps re-capturing pairs while armed. Software may clear only the second flag, and that flag sets again when the next complete pair lands.

Top module: `pulse_pair_capture`

## Requirements
- R1: After reset the control register, both flags, both capture registers and the width output are zero, and the unit is disarmed.
- R2: Each edge select field uses this encoding: 00 detects nothing, 01 detects rising edges, 10 detects falling edges, 11 detects both. With the default two synchronizer stages, an input level first seen at clock edge k is captured with the counter value present at edge k+2.
- R3: Captures happen only while the control bits advanced-enable (bit 0), dual-enable (bit 1) and arm (bit 3) are all 1. Whenever any of them is 0, the sequence returns to waiting for the initial edge.
- R4: While waiting for the initial edge, a match on the first select (control bits 5:4) loads the counter into capture A, sets flag A and moves the unit to waiting for the final edge.
- R5: While waiting for the final edge, a match on the second select (control bits 7:6) loads the counter into capture B, sets flag B and returns the unit to waiting for the initial edge.
- R6: With control bit 2 at 0 (one-shot), a capture into B clears the arm bit in the same cycle, so no further capture occurs until software writes arm again. The hardware clear wins over a simultaneous software write.
- R7: With control bit 2 at 1 (continuous), captures keep alternating while armed. Clearing only flag B leaves flag A set, and flag B sets again on the next completed pair.
- R8: Both capture registers keep their latest values after the arm bit is cleared.
- R9: Writing 1 to bit 0 or bit 1 of the flag register (address 1) clears flag A or flag B. A hardware set in the same cycle wins.
- R10: width_o equals capture B minus capture A modulo 2^CW, so a pulse spanning one counter wrap reports its true length.
- R11: rd_data returns the control byte at address 0, {flag B, flag A} in bits 1:0 at address 1, capture A at address 2 and capture B at address 3, zero-extended. Writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_i | input | CW | Free-running counter value |
| sig_i | input | 1 | Asynchronous measured input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CW | Register read data |
| flag_a_o | output | 1 | Initial-edge captured flag |
| flag_b_o | output | 1 | Pair complete flag |
| armed_o | output | 1 | Current arm bit |
| width_o | output | CW | Capture B minus capture A |

## Verification
The hardest situation to reach is a flag clear written in the very cycle the hardware sets that flag, and a control write landing in the cycle the one-shot disarm fires. Both need the write strobe aligned to within one clock of an edge that has travelled through the synchronizer. A long pseudo-random phase toggles the input and issues flag clears and control writes at random intervals, so these coincidences occur many times. A cycle-level reference model checks every outcome. Directed phases before it place known pulses, including one across a counter wrap, and check the reported widths and the exact capture latency.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic {
    SEQ_WAIT_FIRST  = 1'b0,
    SEQ_WAIT_SECOND = 1'b1
  } seq_state_e;

  // control byte layout, MSB first
  typedef struct packed {
    edge_sel_e sel_b;
    edge_sel_e sel_a;
    logic      arm;
    logic      cont;
    logic      dual_en;
    logic      adv_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = 8;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_FLAGS = 2'd1;
  localparam logic [1:0] ADDR_CAP_A = 2'd2;
  localparam logic [1:0] ADDR_CAP_B = 2'd3;

  function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction

endpackage

// File: rtl/pcap_rst_sync.sv
module pcap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pcap_sync_edge.sv
module pcap_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe_q;
  logic [PIPE_W-1:0] pipe_n;
  logic              cur;
  logic              prev;

  always_comb begin
    pipe_n = {pipe_q[PIPE_W-2:0], sig_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_n;
    end
  end

  assign cur    = pipe_q[SYNC_STAGES-1];
  assign prev   = pipe_q[SYNC_STAGES];
  assign rise_o = cur & ~prev;
  assign fall_o = ~cur & prev;

endmodule

// File: rtl/pcap_seq.sv
module pcap_seq
  import pcap_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  edge_sel_e     sel_a_i,
  input  edge_sel_e     sel_b_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cap_a_evt_o,
  output logic          cap_b_evt_o,
  output logic [CW-1:0] cap_a_o,
  output logic [CW-1:0] cap_b_o
);

  seq_state_e    state_q, state_n;
  logic [CW-1:0] cap_a_q, cap_a_n;
  logic [CW-1:0] cap_b_q, cap_b_n;
  logic          hit_a, hit_b;

  always_comb begin
    hit_a       = edge_hit(sel_a_i, rise_i, fall_i);
    hit_b       = edge_hit(sel_b_i, rise_i, fall_i);
    cap_a_evt_o = active_i & (state_q == SEQ_WAIT_FIRST) & hit_a;
    cap_b_evt_o = active_i & (state_q == SEQ_WAIT_SECOND) & hit_b;

    state_n = state_q;
    if (!active_i) begin
      state_n = SEQ_WAIT_FIRST;
    end else if (cap_a_evt_o) begin
      state_n = SEQ_WAIT_SECOND;
    end else if (cap_b_evt_o) begin
      state_n = SEQ_WAIT_FIRST;
    end

    cap_a_n = cap_a_evt_o ? cnt_i : cap_a_q;
    cap_b_n = cap_b_evt_o ? cnt_i : cap_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_WAIT_FIRST;
      cap_a_q <= '0;
      cap_b_q <= '0;
    end else begin
      state_q <= state_n;
      if (cap_a_evt_o) cap_a_q <= cap_a_n;
      if (cap_b_evt_o) cap_b_q <= cap_b_n;
    end
  end

  assign cap_a_o = cap_a_q;
  assign cap_b_o = cap_b_q;

endmodule

// File: rtl/pcap_regs.sv
module pcap_regs
  import pcap_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          set_a_i,
  input  logic          set_b_i,
  input  logic [CW-1:0] cap_a_i,
  input  logic [CW-1:0] cap_b_i,
  output ctrl_t         ctrl_o,
  output logic          flag_a_o,
  output logic          flag_b_o
);

  ctrl_t ctrl_q, ctrl_n;
  logic  flag_a_q, flag_a_n;
  logic  flag_b_q, flag_b_n;
  logic  wr_ctrl, wr_flags, clr_a, clr_b, disarm;
  logic  unused_wr_hi;

  always_comb begin
    wr_ctrl  = wr_en & (wr_addr == ADDR_CTRL);
    wr_flags = wr_en & (wr_addr == ADDR_FLAGS);
    clr_a    = wr_flags & wr_data[0];
    clr_b    = wr_flags & wr_data[1];
    disarm   = set_b_i & ~ctrl_q.cont;

    ctrl_n = ctrl_q;
    if (wr_ctrl) ctrl_n = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (disarm)  ctrl_n.arm = 1'b0;

    flag_a_n = set_a_i | (flag_a_q & ~clr_a);
    flag_b_n = set_b_i | (flag_b_q & ~clr_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      flag_a_q <= 1'b0;
      flag_b_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_n;
      flag_a_q <= flag_a_n;
      flag_b_q <= flag_b_n;
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_CTRL:  rd_data = {{(CW-CTRL_W){1'b0}}, ctrl_q};
      ADDR_FLAGS: rd_data = {{(CW-2){1'b0}}, flag_b_q, flag_a_q};
      ADDR_CAP_A: rd_data = cap_a_i;
      default:    rd_data = cap_b_i;
    endcase
  end

  assign unused_wr_hi = ^wr_data[CW-1:CTRL_W];
  assign ctrl_o       = ctrl_q;
  assign flag_a_o     = flag_a_q;
  assign flag_b_o     = flag_b_q;

endmodule

// File: rtl/pulse_pair_capture.sv
module pulse_pair_capture
  import pcap_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          sig_i,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          flag_a_o,
  output logic          flag_b_o,
  output logic          armed_o,
  output logic [CW-1:0] width_o
);

  logic          rst_sync_n;
  logic          rise, fall;
  logic          active;
  logic          cap_a_evt, cap_b_evt;
  logic [CW-1:0] cap_a, cap_b;
  logic          ctrl_cont;
  ctrl_t         ctrl;

  pcap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcap_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sig_i  (sig_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign active    = ctrl.adv_en & ctrl.dual_en & ctrl.arm;
  assign ctrl_cont = ctrl.cont;

  pcap_seq #(.CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .active_i    (active),
    .sel_a_i     (ctrl.sel_a),
    .sel_b_i     (ctrl.sel_b),
    .rise_i      (rise),
    .fall_i      (fall),
    .cnt_i       (cnt_i),
    .cap_a_evt_o (cap_a_evt),
    .cap_b_evt_o (cap_b_evt),
    .cap_a_o     (cap_a),
    .cap_b_o     (cap_b)
  );

  pcap_regs #(.CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .set_a_i  (cap_a_evt),
    .set_b_i  (cap_b_evt),
    .cap_a_i  (cap_a),
    .cap_b_i  (cap_b),
    .ctrl_o   (ctrl),
    .flag_a_o (flag_a_o),
    .flag_b_o (flag_b_o)
  );

  assign armed_o = ctrl.arm;
  assign width_o = cap_b - cap_a;

endmodule

// File: rtl/pcap_checker.sv
module pcap_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cont,
  input logic          armed,
  input logic          cap_a_evt,
  input logic          cap_b_evt,
  input logic [CW-1:0] cap_a,
  input logic [CW-1:0] cap_b,
  input logic          flag_a,
  input logic          flag_b
);

  AST_FIRST_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a_evt |=> flag_a); // R4

  AST_FINAL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_b_evt |=> flag_b); // R5

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_b_evt && !cont) |=> !armed); // R6

  AST_IDLE_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> ($stable(cap_a) && $stable(cap_b))); // R3

  AST_CAP_A_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_a_evt |=> $stable(cap_a)); // R8

  AST_CAP_B_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_b_evt |=> $stable(cap_b)); // R8

endmodule

bind pulse_pair_capture pcap_checker #(.CW(CW)) u_pcap_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cont      (ctrl_cont),
  .armed     (armed_o),
  .cap_a_evt (cap_a_evt),
  .cap_b_evt (cap_b_evt),
  .cap_a     (cap_a),
  .cap_b     (cap_b),
  .flag_a    (flag_a_o),
  .flag_b    (flag_b_o)
);

// File: tb/test_pulse_pair_capture.sv
`timescale 1ns/1ps
module test_pulse_pair_capture;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cnt;
  logic          sig;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [CW-1:0] wr_data;
  logic [1:0]    rd_addr;
  logic [CW-1:0] rd_data;
  logic          flag_a, flag_b, armed;
  logic [CW-1:0] width;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pulse_pair_capture #(.CW(CW)) i_pulse_pair_capture (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .sig_i(sig),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_a_o(flag_a), .flag_b_o(flag_b), .armed_o(armed), .width_o(width)
  );

  // free-running counter with an optional jump
  bit            jump_req = 0;
  logic [CW-1:0] jump_val;
  always @(negedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (jump_req) begin cnt <= jump_val; jump_req = 0; end
    else cnt <= cnt + 1'b1;
  end

  // ---------------- reference model ----------------
  bit            m_s1, m_s2, m_s3, m_second, m_fa, m_fb;
  logic [7:0]    m_ctrl;
  logic [CW-1:0] m_ca, m_cb;

  always @(posedge clk) begin
    bit rise, fall, act, ha, hb, ea, eb;
    logic [7:0] nc;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_second = 0; m_fa = 0; m_fb = 0;
      m_ctrl = 0; m_ca = 0; m_cb = 0;
    end else begin
      rise = m_s2 && !m_s3;
      fall = !m_s2 && m_s3;
      act  = m_ctrl[0] && m_ctrl[1] && m_ctrl[3];
      ha   = (m_ctrl[4] && rise) || (m_ctrl[5] && fall);
      hb   = (m_ctrl[6] && rise) || (m_ctrl[7] && fall);
      ea   = act && !m_second && ha;
      eb   = act && m_second && hb;
      nc   = m_ctrl;
      if (wr_en && wr_addr == 2'd0) nc = wr_data[7:0];
      if (eb && !m_ctrl[2]) nc[3] = 1'b0;
      m_fa = ea || (m_fa && !(wr_en && wr_addr == 2'd1 && wr_data[0]));
      m_fb = eb || (m_fb && !(wr_en && wr_addr == 2'd1 && wr_data[1]));
      if (ea) m_ca = cnt;
      if (eb) m_cb = cnt;
      if (!act) m_second = 0;
      else if (ea) m_second = 1;
      else if (eb) m_second = 0;
      m_ctrl = nc;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sig;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] m_rd(logic [1:0] a);
    case (a)
      2'd0:    return {{(CW-8){1'b0}}, m_ctrl};
      2'd1:    return {{(CW-2){1'b0}}, m_fb, m_fa};
      2'd2:    return m_ca;
      default: return m_cb;
    endcase
  endfunction

  // compare every clock, away from the edges
  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      chk(flag_a == m_fa, "R4 flag_a", flag_a, m_fa);
      chk(flag_b == m_fb, "R5 flag_b", flag_b, m_fb);
      chk(armed == m_ctrl[3], "R6 armed", armed, m_ctrl[3]);
      chk(width == CW'(m_cb - m_ca), "R10 width", width, CW'(m_cb - m_ca));
      chk(rd_data == m_rd(rd_addr), "R11 rd_data", rd_data, m_rd(rd_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic peek(logic [1:0] a, output logic [CW-1:0] v);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk); #3;
    v = rd_data;
  endtask

  task automatic pulse(bit lvl, int len);
    @(negedge clk); sig = lvl;
    repeat (len) @(negedge clk);
    sig = ~lvl;
  endtask

  task automatic jump(logic [CW-1:0] v);
    @(posedge clk); #1;
    jump_val = v; jump_req = 1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v, v2;
    logic [15:0] lfsr;
    rst_n = 0; sig = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(5);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      chk(v == 0, "R1 reset register", v, 0);
    end
    chk(armed == 0 && flag_a == 0 && flag_b == 0 && width == 0, "R1 reset outputs",
        {armed, flag_a, flag_b}, 0);

    // positive pulse, one-shot: rising then falling
    wr(1, 3);
    wr(0, 16'h009B);
    @(negedge clk); sig = 1;
    @(posedge clk); #3;
    @(posedge clk); #3;
    chk(flag_a == 0, "R2 latency before k+2", flag_a, 0);
    @(posedge clk); #3;
    chk(flag_a == 1, "R2 capture at k+2", flag_a, 1);
    idle(5); sig = 0;
    idle(6);
    chk(width == 7, "R10 positive pulse width", width, 7);
    chk(flag_b == 1, "R5 pair complete", flag_b, 1);
    chk(armed == 0, "R6 one-shot disarm", armed, 0);
    peek(2, v);
    pulse(1, 4); idle(6);
    chk(width == 7, "R6 no capture after disarm", width, 7);
    peek(2, v2);
    chk(v2 == v, "R8 capture A retained", v2, v);

    // negative pulse: falling then rising
    sig = 1; idle(4);
    wr(1, 3);
    wr(0, 16'h006B);
    idle(3);
    pulse(0, 5); idle(6);
    chk(width == 5, "R10 negative pulse width", width, 5);
    chk(armed == 0, "R6 one-shot disarm negative", armed, 0);
    sig = 0; idle(4);

    // continuous mode
    wr(1, 3);
    wr(0, 16'h009F);
    pulse(1, 3); idle(6);
    chk(flag_b == 1 && width == 3, "R7 first continuous pair", width, 3);
    wr(1, 2);
    idle(1);
    chk(flag_b == 0 && flag_a == 1, "R9 clear only flag B", {flag_b, flag_a}, 2'b01);
    pulse(1, 6); idle(6);
    chk(flag_b == 1, "R7 flag B sets again", flag_b, 1);
    chk(width == 6, "R7 new pair width", width, 6);
    chk(armed == 1, "R7 stays armed", armed, 1);

    // counter wrap between edges
    jump(16'hFFFA);
    pulse(1, 9); idle(6);
    chk(width == 9, "R10 width across wrap", width, 9);
    peek(3, v);
    chk(v < 16'h0010, "R10 capture B wrapped", v, 3);

    // disarm in continuous mode, values retained
    wr(0, 16'h0097);
    pulse(1, 5); idle(6);
    chk(width == 9, "R8 values kept after disarm", width, 9);

    // gating by enables
    wr(1, 3);
    wr(0, 16'h0099);
    pulse(1, 4); idle(6);
    chk(flag_a == 0 && width == 9, "R3 dual enable low blocks", flag_a, 0);
    wr(0, 16'h009A);
    pulse(1, 4); idle(6);
    chk(flag_a == 0 && width == 9, "R3 advanced enable low blocks", flag_a, 0);

    // either-edge select measures between any two edges
    wr(0, 16'h00FB);
    pulse(1, 4); idle(6);
    chk(width == 4, "R2 either-edge interval", width, 4);
    // select 00 detects nothing
    wr(1, 3);
    wr(0, 16'h008B);
    pulse(1, 4); idle(6);
    chk(flag_a == 0, "R2 select 00 ignores edges", flag_a, 0);

    // writes to capture addresses ignored
    peek(2, v);
    wr(2, 16'h1234);
    peek(2, v2);
    chk(v2 == v, "R11 capture A not writable", v2, v);

    // random phase: coincident clears, sets and control writes
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 0) sig = ~sig;
      rd_addr = lfsr[9:8];
      wr_en = 0;
      if (lfsr[6:4] == 3'b101) begin
        wr_en = 1; wr_addr = 1; wr_data = {14'd0, lfsr[12:11]};
      end else if (lfsr[7:3] == 5'b11000) begin
        wr_en = 1; wr_addr = 0; wr_data = {8'd0, lfsr[15:12], 1'b1, lfsr[1], 2'b11};
      end
    end
    @(negedge clk); wr_en = 0;
    idle(4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule